// File: doc/BRIEF.md
# Dual-Bank Interleaved Trace Filter

This block watches the access ports of two 64-bit RAM banks that together form one contiguous byte address space. The banks alternate every 8 bytes: bank 0 holds the even 64-bit words and bank 1 the odd ones. Each bank has its own region comparator, with an enable, a start address and a power-of-two size. An access that falls inside its bank's region, and is of a type the qualifier selects, is forwarded as a single hit strobe. The hit carries the rebuilt full byte address, the write flag, the byte enables and the 64-bit data, and goes to a downstream trace queue.

The bank port does not show which part of a 64-bit read the processor wanted. For that reason, raw-data capture mode (32-bit transfers without status) never forwards reads, and a mode-error output flags a configuration that asks for them. On ECC-protected memory, a partial write reaches the bank as a read-modify-write of the whole word. In that case only full 64-bit writes are traced. A configuration-error output flags two enabled regions that are programmed differently, because such a pair captures only every other word of the intended range. When both banks hit in the same cycle, the hits are serialised through a small pending queue with bank 0 first.

Top module: `ilv_trace_filter`

## Requirements
- R1: The forwarded address is {bank word index, bank id, 3'b000}, with bank id 0 for bank 0 and 1 for bank 1, so that bit 3 selects the bank.
- R2: A bank hits only if its region is enabled and ((address ^ start) >> log2) == 0. A log2 of AW or more covers the whole space, and start bits below the region size are ignored. A disabled bank never hits.
- R3: A hit appears on hit_vld_o in the cycle after the access, carrying the access's write flag, data and byte enables. Reads report all-ones byte enables.
- R4: When both banks hit in the same cycle with nothing pending, the bank 0 hit is output in the next cycle and the bank 1 hit in the cycle after that.
- R5: qual_i[0]=1 enables tracing of reads and qual_i[1]=1 enables tracing of writes. A disabled access type never hits.
- R6: With direct_i=1, reads are never forwarded, and writes still are. mode_err_o = direct_i & qual_i[0].
- R7: With ecc_i=1, a write whose byte enables are not all ones is not forwarded. With ecc_i=0, such a write is forwarded with its byte enables.
- R8: cfg_err_o is 1 exactly when both regions are enabled and their start or log2 values differ.
- R9: Hits that cannot be output at once wait in a queue of PEND_D entries and leave in arrival order, bank 0 before bank 1 within a cycle. A hit that finds the queue full is dropped, and lost_o pulses for one cycle, aligned with the output update of that cycle.
- R10: After reset, hit_vld_o and lost_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_vld_i | input | 2 | Access strobe per bank |
| bank_word_i | input | 2 x (AW-4) | Word index within each bank |
| bank_we_i | input | 2 | Write flag per bank |
| bank_be_i | input | 2 x 8 | Write byte enables per bank |
| bank_data_i | input | 2 x 64 | Access data per bank |
| ecc_i | input | 1 | Memory is ECC protected |
| direct_i | input | 1 | Raw 32-bit data capture mode |
| qual_i | input | 2 | Bit 0 traces reads, bit 1 traces writes |
| rgn_en_i | input | 2 | Region enable per bank |
| rgn_start_i | input | 2 x AW | Region start byte address per bank |
| rgn_log2_i | input | 2 x LW | Region size exponent per bank |
| hit_vld_o | output | 1 | Hit strobe |
| hit_addr_o | output | AW | Full byte address of the hit |
| hit_we_o | output | 1 | Hit was a write |
| hit_be_o | output | 8 | Byte enables of the hit |
| hit_data_o | output | 64 | Data of the hit |
| lost_o | output | 1 | A hit was dropped this cycle |
| mode_err_o | output | 1 | Mode cannot trace the selected access type |
| cfg_err_o | output | 1 | Enabled bank regions disagree |

## Verification
The bench builds the block with AW=8 and PEND_D=2. The 256-byte space gives 16 words per bank, which makes it possible to sweep every word of both banks against every 8-byte-aligned start and several region sizes. Each hit decision and address is compared with an arithmetic model. The two-entry queue fills after three consecutive cycles of dual-bank hits, so the drop path, the lost pulse and the drain order all fall within a short directed sequence.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int unsigned TF_DW  = 64;
  localparam int unsigned TF_BEW = TF_DW / 8;
  localparam int unsigned TF_NB  = 2;
  localparam int unsigned QUAL_RD = 0;
  localparam int unsigned QUAL_WR = 1;
endpackage

// File: rtl/tf_bank_filter.sv
module tf_bank_filter
  import tf_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned BANK = 0,
  localparam int unsigned WW  = AW - 4,
  localparam int unsigned LW  = $clog2(AW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [WW-1:0]     word_i,
  input  logic              we_i,
  input  logic [TF_BEW-1:0] be_i,
  input  logic [TF_DW-1:0]  data_i,
  input  logic              ecc_i,
  input  logic              direct_i,
  input  logic [1:0]        qual_i,
  input  logic              en_i,
  input  logic [AW-1:0]     start_i,
  input  logic [LW-1:0]     log2_i,
  output logic              hit_o,
  output logic [AW-1:0]     addr_o,
  output logic              we_o,
  output logic [TF_BEW-1:0] be_o,
  output logic [TF_DW-1:0]  data_o
);
  localparam bit BANK_BIT = (BANK != 0);

  logic [AW-1:0] full_addr;
  logic [AW-1:0] hi_mask;
  logic          in_rgn;
  logic          acc_ok;

  assign full_addr = {word_i, BANK_BIT, 3'b000};

  always_comb begin
    for (int i = 0; i < AW; i++) hi_mask[i] = (i >= int'(log2_i));
  end

  assign in_rgn = (((full_addr ^ start_i) & hi_mask) == '0);

  // reads carry no lane info, so raw-data mode cannot use them
  always_comb begin
    if (we_i) acc_ok = qual_i[QUAL_WR] & (~ecc_i | (&be_i));
    else      acc_ok = qual_i[QUAL_RD] & ~direct_i;
  end

  assign hit_o  = vld_i & en_i & in_rgn & acc_ok;
  assign addr_o = full_addr;
  assign we_o   = we_i;
  assign be_o   = we_i ? be_i : '1;
  assign data_o = data_i;

  a_r1_bank_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (addr_o[3] == BANK_BIT));
  a_r7_ecc_partial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecc_i && we_i && !(&be_i)) |-> !hit_o);
  a_r6_direct_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (direct_i && !we_i) |-> !hit_o);
  a_r2_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !hit_o);
endmodule

// File: rtl/tf_cfg_check.sv
module tf_cfg_check #(
  parameter int unsigned AW = 16,
  localparam int unsigned LW = $clog2(AW + 1)
) (
  input  logic                 direct_i,
  input  logic [1:0]           qual_i,
  input  logic [1:0]           en_i,
  input  logic [1:0][AW-1:0]   start_i,
  input  logic [1:0][LW-1:0]   log2_i,
  output logic                 mode_err_o,
  output logic                 cfg_err_o
);
  logic differ;

  assign mode_err_o = direct_i & qual_i[tf_pkg::QUAL_RD];
  assign differ     = (start_i[0] != start_i[1]) | (log2_i[0] != log2_i[1]);
  assign cfg_err_o  = (&en_i) & differ;
endmodule

// File: rtl/tf_hit_merge.sv
module tf_hit_merge #(
  parameter int unsigned HW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          in_vld_i,
  input  logic [1:0][HW-1:0]  in_pkt_i,
  output logic                out_vld_o,
  output logic [HW-1:0]       out_pkt_o,
  output logic                lost_o
);
  logic [HW-1:0] mem [DEPTH];
  logic [PW-1:0] rp_q, wp_q;
  logic [CW-1:0] cnt_q;

  logic          have_q;
  logic          take_vld;
  logic [HW-1:0] take_pkt;
  logic          pa_vld, pb_vld;
  logic [HW-1:0] pa_pkt, pb_pkt;
  logic [CW:0]   room;
  logic          acc_a, acc_b, lost_c;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    if (int'(p) == DEPTH - 1) return '0;
    return p + 1'b1;
  endfunction

  assign have_q = (cnt_q != '0);

  always_comb begin
    take_vld = 1'b0;
    take_pkt = in_pkt_i[0];
    pa_vld   = 1'b0;
    pa_pkt   = in_pkt_i[0];
    pb_vld   = 1'b0;
    pb_pkt   = in_pkt_i[1];
    if (have_q) begin
      take_vld = 1'b1;
      take_pkt = mem[rp_q];
      pa_vld   = |in_vld_i;
      pa_pkt   = in_vld_i[0] ? in_pkt_i[0] : in_pkt_i[1];
      pb_vld   = &in_vld_i;
    end else if (in_vld_i[0]) begin
      take_vld = 1'b1;
      take_pkt = in_pkt_i[0];
      pa_vld   = in_vld_i[1];
      pa_pkt   = in_pkt_i[1];
    end else if (in_vld_i[1]) begin
      take_vld = 1'b1;
      take_pkt = in_pkt_i[1];
    end
  end

  assign room   = (CW+1)'(DEPTH) - {1'b0, cnt_q} + {{CW{1'b0}}, have_q};
  assign acc_a  = pa_vld & (room >= (CW+1)'(1));
  assign acc_b  = pb_vld & (room >= (CW+1)'(2));
  assign lost_c = (pa_vld & ~acc_a) | (pb_vld & ~acc_b);

  always_ff @(posedge clk_i) begin
    if (acc_a) mem[wp_q] <= pa_pkt;
    if (acc_b) mem[ptr_inc(wp_q)] <= pb_pkt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q      <= '0;
      wp_q      <= '0;
      cnt_q     <= '0;
      out_vld_o <= 1'b0;
      out_pkt_o <= '0;
      lost_o    <= 1'b0;
    end else begin
      out_vld_o <= take_vld;
      if (take_vld) out_pkt_o <= take_pkt;
      lost_o <= lost_c;
      if (have_q) rp_q <= ptr_inc(rp_q);
      if (acc_b)      wp_q <= ptr_inc(ptr_inc(wp_q));
      else if (acc_a) wp_q <= ptr_inc(wp_q);
      cnt_q <= cnt_q - CW'(have_q) + CW'(acc_a) + CW'(acc_b);
    end
  end

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= DEPTH);
  a_r9_lost_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> (int'(cnt_q) == DEPTH));
  a_r3_hit_emerges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|in_vld_i) |=> out_vld_o);
  a_r4_bank0_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!have_q && (&in_vld_i)) |=> (out_vld_o && out_pkt_o == $past(in_pkt_i[0])));
endmodule

// File: rtl/ilv_trace_filter.sv
module ilv_trace_filter
  import tf_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned PEND_D = 4,
  localparam int unsigned WW    = AW - 4,
  localparam int unsigned LW    = $clog2(AW + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              bank_vld_i,
  input  logic [1:0][WW-1:0]      bank_word_i,
  input  logic [1:0]              bank_we_i,
  input  logic [1:0][TF_BEW-1:0]  bank_be_i,
  input  logic [1:0][TF_DW-1:0]   bank_data_i,
  input  logic                    ecc_i,
  input  logic                    direct_i,
  input  logic [1:0]              qual_i,
  input  logic [1:0]              rgn_en_i,
  input  logic [1:0][AW-1:0]      rgn_start_i,
  input  logic [1:0][LW-1:0]      rgn_log2_i,
  output logic                    hit_vld_o,
  output logic [AW-1:0]           hit_addr_o,
  output logic                    hit_we_o,
  output logic [TF_BEW-1:0]       hit_be_o,
  output logic [TF_DW-1:0]        hit_data_o,
  output logic                    lost_o,
  output logic                    mode_err_o,
  output logic                    cfg_err_o
);
  localparam int unsigned HW = AW + 1 + TF_BEW + TF_DW;

  logic [1:0]         bk_hit;
  logic [1:0][HW-1:0] bk_pkt;
  logic [HW-1:0]      out_pkt;

  for (genvar b = 0; b < TF_NB; b++) begin : g_bank
    logic [AW-1:0]     f_addr;
    logic              f_we;
    logic [TF_BEW-1:0] f_be;
    logic [TF_DW-1:0]  f_data;

    tf_bank_filter #(.AW(AW), .BANK(b)) u_flt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .vld_i    (bank_vld_i[b]),
      .word_i   (bank_word_i[b]),
      .we_i     (bank_we_i[b]),
      .be_i     (bank_be_i[b]),
      .data_i   (bank_data_i[b]),
      .ecc_i    (ecc_i),
      .direct_i (direct_i),
      .qual_i   (qual_i),
      .en_i     (rgn_en_i[b]),
      .start_i  (rgn_start_i[b]),
      .log2_i   (rgn_log2_i[b]),
      .hit_o    (bk_hit[b]),
      .addr_o   (f_addr),
      .we_o     (f_we),
      .be_o     (f_be),
      .data_o   (f_data)
    );
    assign bk_pkt[b] = {f_addr, f_we, f_be, f_data};
  end

  tf_hit_merge #(.HW(HW), .DEPTH(PEND_D)) u_merge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_vld_i  (bk_hit),
    .in_pkt_i  (bk_pkt),
    .out_vld_o (hit_vld_o),
    .out_pkt_o (out_pkt),
    .lost_o    (lost_o)
  );

  assign {hit_addr_o, hit_we_o, hit_be_o, hit_data_o} = out_pkt;

  tf_cfg_check #(.AW(AW)) u_cfg (
    .direct_i   (direct_i),
    .qual_i     (qual_i),
    .en_i       (rgn_en_i),
    .start_i    (rgn_start_i),
    .log2_i     (rgn_log2_i),
    .mode_err_o (mode_err_o),
    .cfg_err_o  (cfg_err_o)
  );

  a_r8_one_enabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rgn_en_i != 2'b11) |-> !cfg_err_o);
  a_r8_match_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rgn_start_i[0] == rgn_start_i[1] && rgn_log2_i[0] == rgn_log2_i[1]) |-> !cfg_err_o);
  a_r10_lost_needs_dual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bk_hit == 2'b00) |=> !lost_o);
endmodule

// File: tb/sim_ilv_trace_filter.sv
module sim_ilv_trace_filter;
  localparam int AW = 8;
  localparam int PD = 2;
  localparam int WW = AW - 4;
  localparam int LW = $clog2(AW + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]          bank_vld;
  logic [1:0][WW-1:0]  bank_word;
  logic [1:0]          bank_we;
  logic [1:0][7:0]     bank_be;
  logic [1:0][63:0]    bank_data;
  logic                ecc, direct;
  logic [1:0]          qual;
  logic [1:0]          rgn_en;
  logic [1:0][AW-1:0]  rgn_start;
  logic [1:0][LW-1:0]  rgn_log2;
  logic                hit_vld, hit_we, lost, mode_err, cfg_err;
  logic [AW-1:0]       hit_addr;
  logic [7:0]          hit_be;
  logic [63:0]         hit_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ilv_trace_filter #(.AW(AW), .PEND_D(PD)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bank_vld_i(bank_vld), .bank_word_i(bank_word), .bank_we_i(bank_we),
    .bank_be_i(bank_be), .bank_data_i(bank_data),
    .ecc_i(ecc), .direct_i(direct), .qual_i(qual),
    .rgn_en_i(rgn_en), .rgn_start_i(rgn_start), .rgn_log2_i(rgn_log2),
    .hit_vld_o(hit_vld), .hit_addr_o(hit_addr), .hit_we_o(hit_we),
    .hit_be_o(hit_be), .hit_data_o(hit_data),
    .lost_o(lost), .mode_err_o(mode_err), .cfg_err_o(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    bank_vld = '0; bank_we = '0; bank_be = '0; bank_word = '0; bank_data = '0;
  endtask

  task automatic set_rgn(input int b, input bit en, input int start, input int l2);
    rgn_en[b]    = en;
    rgn_start[b] = AW'(start);
    rgn_log2[b]  = LW'(l2);
  endtask

  task automatic put(input int b, input int w, input bit we, input logic [7:0] be, input logic [63:0] d);
    bank_vld[b]  = 1'b1;
    bank_word[b] = WW'(w);
    bank_we[b]   = we;
    bank_be[b]   = be;
    bank_data[b] = d;
  endtask

  // one access, checked in the following cycle
  task automatic one(input string tag, input int b, input int w, input bit we,
                     input logic [7:0] be, input logic [63:0] d, input bit exp_hit);
    put(b, w, we, be, d);
    @(negedge clk);
    chk(hit_vld == exp_hit, tag, 64'(hit_vld), 64'(exp_hit));
    if (exp_hit && hit_vld)
      chk(hit_data == d && hit_we == we && hit_be == (we ? be : 8'hFF) &&
          hit_addr == AW'(w * 16 + b * 8), tag, hit_data, d);
    clr();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clr();
    ecc = 0; direct = 0; qual = 2'b11;
    rgn_en = '0; rgn_start = '0; rgn_log2 = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(hit_vld == 0 && lost == 0, "R10 reset outputs", {hit_vld, lost}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hit_vld == 0 && cfg_err == 0 && mode_err == 0, "R10 after release", {hit_vld, cfg_err, mode_err}, 0);

    // R2 R1 R3 sweep: every word of both banks against aligned starts and sizes
    for (int li = 0; li < 4; li++) begin
      int l2;
      l2 = (li == 0) ? 3 : (li == 1) ? 4 : (li == 2) ? 5 : 8;
      for (int s = 0; s < 32; s++) begin
        set_rgn(0, 1, s * 8, l2);
        set_rgn(1, 1, s * 8, l2);
        for (int b = 0; b < 2; b++) begin
          for (int w = 0; w < 16; w++) begin
            int a;
            bit eh, we;
            logic [63:0] d;
            a  = w * 16 + b * 8;
            eh = ((a ^ (s * 8)) >> l2) == 0;
            we = w[0];
            d  = {32'(s), 8'(l2), 8'(b), 16'(w)} ^ 64'hA5A5_0000_5A5A_0000;
            put(b, w, we, 8'hFF, d);
            @(negedge clk);
            chk(hit_vld == eh, "R2 region sweep", 64'(hit_vld), 64'(eh));
            if (eh && hit_vld) begin
              chk(hit_addr == AW'(a), "R1 address rebuild", 64'(hit_addr), 64'(a));
              chk(hit_data == d && hit_we == we, "R3 data forward", hit_data, d);
            end
            clr();
          end
        end
      end
    end

    // R2 size exponent above AW covers all; unaligned low start bits ignored; disabled bank
    set_rgn(0, 1, 8'hC8, 12); set_rgn(1, 1, 8'hC8, 12);
    one("R2 whole space", 0, 1, 0, 8'h00, 64'h11, 1);
    set_rgn(0, 1, 8'h47, 6); set_rgn(1, 1, 8'h47, 6);
    one("R2 unaligned start in", 1, 4, 1, 8'hFF, 64'h22, 1);
    one("R2 unaligned start out", 0, 0, 1, 8'hFF, 64'h23, 0);
    set_rgn(0, 1, 0, 6); set_rgn(1, 0, 0, 6);
    one("R2 bank0 enabled", 0, 0, 0, 8'h00, 64'h24, 1);
    one("R2 bank1 disabled", 1, 0, 0, 8'h00, 64'h25, 0);

    // R5 qualifier
    set_rgn(1, 1, 0, 8); set_rgn(0, 1, 0, 8);
    qual = 2'b00;
    one("R5 none read", 0, 2, 0, 8'h00, 64'h31, 0);
    one("R5 none write", 1, 2, 1, 8'hFF, 64'h32, 0);
    qual = 2'b01;
    one("R5 reads read", 0, 3, 0, 8'h00, 64'h33, 1);
    one("R5 reads write", 0, 3, 1, 8'hFF, 64'h34, 0);
    qual = 2'b10;
    one("R5 writes read", 1, 3, 0, 8'h00, 64'h35, 0);
    one("R5 writes write", 1, 3, 1, 8'hFF, 64'h36, 1);

    // R6 raw-data mode
    qual = 2'b11; direct = 1;
    #1 chk(mode_err == 1, "R6 mode error set", 64'(mode_err), 1);
    one("R6 direct read dropped", 0, 5, 0, 8'h00, 64'h41, 0);
    one("R6 direct write kept", 1, 5, 1, 8'hFF, 64'h42, 1);
    qual = 2'b10;
    #1 chk(mode_err == 0, "R6 mode error clear", 64'(mode_err), 0);
    direct = 0; qual = 2'b11;

    // R7 ECC and R3 byte enables
    ecc = 1;
    one("R7 ecc partial dropped", 0, 6, 1, 8'h0F, 64'h51, 0);
    one("R7 ecc full kept", 0, 6, 1, 8'hFF, 64'h52, 1);
    ecc = 0;
    one("R7 no ecc partial kept", 1, 6, 1, 8'h0F, 64'h53, 1);
    one("R3 read be all ones", 1, 7, 0, 8'h00, 64'h54, 1);

    // R8 configuration error
    set_rgn(0, 1, 16, 4); set_rgn(1, 1, 16, 4);
    #1 chk(cfg_err == 0, "R8 matching", 64'(cfg_err), 0);
    set_rgn(1, 1, 32, 4);
    #1 chk(cfg_err == 1, "R8 start differs", 64'(cfg_err), 1);
    set_rgn(1, 1, 16, 5);
    #1 chk(cfg_err == 1, "R8 size differs", 64'(cfg_err), 1);
    set_rgn(1, 0, 32, 5);
    #1 chk(cfg_err == 0, "R8 one disabled", 64'(cfg_err), 0);

    // R4 both banks in one cycle
    set_rgn(0, 1, 0, 8); set_rgn(1, 1, 0, 8);
    @(negedge clk);
    put(0, 9, 1, 8'hFF, 64'h61); put(1, 9, 1, 8'hFF, 64'h62);
    @(negedge clk); clr();
    chk(hit_vld && hit_data == 64'h61 && hit_addr == AW'(9*16), "R4 bank0 first", hit_data, 64'h61);
    @(negedge clk);
    chk(hit_vld && hit_data == 64'h62 && hit_addr == AW'(9*16+8), "R4 bank1 second", hit_data, 64'h62);
    @(negedge clk);
    chk(!hit_vld, "R4 idle after", 64'(hit_vld), 0);

    // R9 queue overflow: three cycles of dual hits into a 2-entry queue
    for (int c = 0; c < 3; c++) begin
      put(0, c, 1, 8'hFF, 64'h70 + 64'(2*c)); put(1, c, 1, 8'hFF, 64'h71 + 64'(2*c));
      @(negedge clk);
      if (c == 0) chk(hit_data == 64'h70 && !lost, "R9 drain a0", hit_data, 64'h70);
      if (c == 1) chk(hit_data == 64'h71 && !lost, "R9 drain a1", hit_data, 64'h71);
      if (c == 2) begin
        chk(hit_data == 64'h72, "R9 drain b0", hit_data, 64'h72);
        chk(lost == 1, "R9 lost pulse", 64'(lost), 1);
      end
    end
    clr();
    @(negedge clk);
    chk(hit_vld && hit_data == 64'h73 && !lost, "R9 drain b1", hit_data, 64'h73);
    @(negedge clk);
    chk(hit_vld && hit_data == 64'h74, "R9 drain c0", hit_data, 64'h74);
    @(negedge clk);
    chk(!hit_vld && !lost, "R9 c1 dropped", {hit_vld, lost}, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule